// File: doc/BRIEF.md
# Reloadable Tick Watchdog with Register Window

This block is a watchdog timer that sits behind a 32-byte register window. It has a ten-bit down-counter. The counter steps once per tick, and a parameterised prescaler divides the core clock to make that tick. At the nominal rate one tick is 0.6 s, so a timeout of T seconds is programmed as T*10/6 ticks.

Software writes the start count into an initial-value register. Any write to offset 0x00 reloads the counter from that register and restarts the prescaler. A read of offset 0x00 returns the live count. A halt bit in the control register freezes the timer, and this bit is set out of reset.

The first expiry does three things:
- it sets a timeout status bit;
- it reloads the counter;
- it starts a second period.

If that second period also runs out with no software reload in between, the block asks for a one-cycle system reset. A guard flag, which is also set out of reset, can block that reset. In that case the block records that a reset was withheld.

Register accesses are plain single-cycle strobes. A write is taken on the clock edge at which `wr_en` is high. A read is combinational from `addr`. The register port never stalls, so there is no back-pressure to manage.

Top module: `tick_watchdog`

## Requirements
- R1: Out of reset the registers read as follows, and `sys_rst_req` is 0:

  | Offset | Reset read value | Meaning |
  |---|---|---|
  | 0x08 | 0x0800 | halt set |
  | 0x0C | 0x0001 | guard set |
  | 0x12 | 0x0004 | initial value |
  | 0x00 | 0x0004 | live count |
  | 0x04 | 0x0000 | status |
  | 0x06 | 0x0000 | status |

- R2: At offset 0x12 the initial count lives in bits [9:0]. A write whose bits [9:0] are below 4 is ignored, and the old value stays. Any other write stores bits [9:0]. Bits [15:10] always read 0, whatever is written to them.
- R3: A write of any data to offset 0x00 loads the counter from the initial value and restarts the prescaler. This works even while the timer is halted. A read of 0x00 returns the count in bits [9:0] with zeros above.
- R4: Bit 11 at offset 0x08 is the halt bit, and it reads back as written. While it is 1, the count does not change and no tick is produced.
- R5: While the timer runs, take a reload at clock edge e0 with initial value N and PRESCALE = P. The count then reads N-k after edge e0+k*P, for k = 0..N.
- R6: The count is 0 and a tick arrives: this is an expiry. The count reloads to N. On the first expiry since the last reload, bit 0 at offset 0x04 is set.
- R7: A second expiry with no reload in between behaves as follows:
  - If the guard is 0, `sys_rst_req` is high for exactly the one cycle after that edge, and bit 0 at offset 0x06 is set.
  - If the guard is 1, `sys_rst_req` stays low and bit 1 at offset 0x06 is set instead.
- R8: Bit 0 at offset 0x0C is the guard flag. It can be cleared and set, and a read shows the written state.
- R9: Status bits are write-1-to-clear. Writing 1 to 0x04 bit 0 clears the timeout bit. Writing 3 to 0x06 clears both of its bits. If a status bit is set and cleared in the same cycle, the set wins.
- R10: A reload clears the record of a first expiry, so the next expiry counts as a first one again. If a reload write falls on the very edge of an expiry, the reload wins: no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | 1 | register write strobe |
| addr | input | 5 | byte offset in the register window |
| wdata | input | 16 | write data |
| rdata | output | 16 | read data for `addr` (combinational) |
| sys_rst_req | output | 1 | one-cycle system reset request |

## Verification
A software reload and a counter expiry can land on the same clock edge. The bench times the reload write so that it hits the exact edge on which the counter would wrap from zero. That edge is computed from the reload edge, N and the prescale value. The bench then expects the count to equal N and the timeout status to stay clear.

A status clear can also fall on the edge of an expiry. The same timing places a write-1-to-clear on the first-expiry edge, and the bench expects the timeout bit to remain set.

// File: rtl/tick_wdt_pkg.sv
package tick_wdt_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STS_A  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STS_B  = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_GUARD  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_INIT   = 5'h12;

  localparam int unsigned HALT_BIT  = 11;
  localparam int unsigned GUARD_BIT = 0;
  localparam int unsigned TO_BIT    = 0;
  localparam int unsigned RPT_BIT   = 0;
  localparam int unsigned BLK_BIT   = 1;

  // expiry events, one cycle each
  typedef struct packed {
    logic first;      // first expiry since reload
    logic rpt_fire;   // repeated expiry, reset allowed
    logic rpt_block;  // repeated expiry, reset withheld by guard
  } expiry_ev_t;
endpackage

// File: rtl/tick_wdt_prescale.sv
module tick_wdt_prescale #(
  parameter int unsigned PRESCALE = 30_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      localparam int unsigned PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pre_q;
      logic at_last;

      assign at_last = (pre_q == LAST);
      assign tick    = run && at_last;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pre_q <= '0;
        else if (!run || restart)   pre_q <= '0;
        else if (at_last)           pre_q <= '0;
        else                        pre_q <= pre_q + 1'b1;
      end

      // R5
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tick_wdt_count.sv
module tick_wdt_count
  import tick_wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned INIT_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] init_val,
  input  logic             guard,
  output logic [CNT_W-1:0] cnt,
  output expiry_ev_t       ev,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic             rst_q;
  logic             expire;

  assign expire = tick && !reload && (cnt_q == '0);

  always_comb begin
    ev.first     = expire && !seen_q;
    ev.rpt_fire  = expire &&  seen_q && !guard;
    ev.rpt_block = expire &&  seen_q &&  guard;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(INIT_RST);
      seen_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= ev.rpt_fire;
      if (reload) begin
        cnt_q  <= init_val;
        seen_q <= 1'b0;
      end else if (tick) begin
        if (cnt_q == '0) begin
          cnt_q  <= init_val;
          seen_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt     = cnt_q;
  assign rst_req = rst_q;

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q);
  // R7
  rst_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> !$past(guard));
  // R3
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == $past(init_val)));
  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reload) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_wdt_regs.sv
module tick_wdt_regs
  import tick_wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned MIN_INIT = 4,
  parameter int unsigned INIT_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  expiry_ev_t        ev,
  output logic [REG_W-1:0]  rdata,
  output logic              halt,
  output logic              guard,
  output logic [CNT_W-1:0]  init_val,
  output logic              reload
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_INIT);

  logic [CNT_W-1:0] init_q;
  logic halt_q, guard_q, sts_to_q, sts_rpt_q, sts_blk_q;
  logic hit_init, hit_ctrl, hit_guard, hit_sa, hit_sb, init_ok;

  assign hit_init  = wr_en && (addr == OFS_INIT);
  assign hit_ctrl  = wr_en && (addr == OFS_CTRL);
  assign hit_guard = wr_en && (addr == OFS_GUARD);
  assign hit_sa    = wr_en && (addr == OFS_STS_A);
  assign hit_sb    = wr_en && (addr == OFS_STS_B);
  assign reload    = wr_en && (addr == OFS_RELOAD);
  assign init_ok   = (wdata[CNT_W-1:0] >= MIN_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q    <= CNT_W'(INIT_RST);
      halt_q    <= 1'b1;
      guard_q   <= 1'b1;
      sts_to_q  <= 1'b0;
      sts_rpt_q <= 1'b0;
      sts_blk_q <= 1'b0;
    end else begin
      if (hit_init && init_ok) init_q  <= wdata[CNT_W-1:0];
      if (hit_ctrl)            halt_q  <= wdata[HALT_BIT];
      if (hit_guard)           guard_q <= wdata[GUARD_BIT];
      sts_to_q  <= (sts_to_q  & ~(hit_sa && wdata[TO_BIT]))  | ev.first;
      sts_rpt_q <= (sts_rpt_q & ~(hit_sb && wdata[RPT_BIT])) | ev.rpt_fire;
      sts_blk_q <= (sts_blk_q & ~(hit_sb && wdata[BLK_BIT])) | ev.rpt_block;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_RELOAD: rdata[CNT_W-1:0] = cnt;
      OFS_STS_A:  rdata[TO_BIT]    = sts_to_q;
      OFS_STS_B: begin
        rdata[RPT_BIT] = sts_rpt_q;
        rdata[BLK_BIT] = sts_blk_q;
      end
      OFS_CTRL:   rdata[HALT_BIT]  = halt_q;
      OFS_GUARD:  rdata[GUARD_BIT] = guard_q;
      OFS_INIT:   rdata[CNT_W-1:0] = init_q;
      default:    rdata = '0;
    endcase
  end

  assign halt     = halt_q;
  assign guard    = guard_q;
  assign init_val = init_q;

  // R2
  init_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_q >= MIN_V);
  // R2
  init_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_init && (wdata[CNT_W-1:0] < MIN_V)) |=> $stable(init_q));
  // R6
  first_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.first |=> sts_to_q);
  // R7
  block_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.rpt_block |=> sts_blk_q);
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import tick_wdt_pkg::*;
#(
  parameter int unsigned PRESCALE = 30_000_000,
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned MIN_INIT = 4,
  parameter int unsigned INIT_RST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        sys_rst_req
);
  logic             halt, guard, reload, tick;
  logic [CNT_W-1:0] init_val, cnt;
  expiry_ev_t       ev;

  tick_wdt_regs #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT), .INIT_RST(INIT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt), .ev(ev), .rdata(rdata), .halt(halt), .guard(guard),
    .init_val(init_val), .reload(reload)
  );

  tick_wdt_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(!halt), .restart(reload), .tick(tick)
  );

  tick_wdt_count #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload),
    .init_val(init_val), .guard(guard), .cnt(cnt), .ev(ev),
    .rst_req(sys_rst_req)
  );

  // R4
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !tick);
endmodule

// File: tb/tick_watchdog_tb_top.sv
module tick_watchdog_tb_top;
  localparam int P = 3;
  localparam logic [4:0] A_RLD = 5'h00, A_SA = 5'h04, A_SB = 5'h06,
                         A_CTL = 5'h08, A_GRD = 5'h0C, A_INI = 5'h12;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, sys_rst_req;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tick_watchdog #(.PRESCALE(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sys_rst_req(sys_rst_req)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic rchk(input string tag, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rchk("R1 ctrl", A_CTL, 16'h0800);
    rchk("R1 guard", A_GRD, 16'h0001);
    rchk("R1 init", A_INI, 16'h0004);
    rchk("R1 count", A_RLD, 16'h0004);
    rchk("R1 stsA", A_SA, 16'h0000);
    rchk("R1 stsB", A_SB, 16'h0000);
    chk("R1 rst", {15'd0, sys_rst_req}, 16'h0000);

    // R2 rejected values and reserved bits
    for (int v = 0; v < 4; v++) begin
      wr(A_INI, 16'(v));
      rchk("R2 reject", A_INI, 16'h0004);
    end
    wr(A_INI, 16'hFC09);
    rchk("R2 accept", A_INI, 16'h0009);
    wr(A_INI, 16'hFC03);
    rchk("R2 reject hi", A_INI, 16'h0009);

    // R4 halted; R3 reload works while halted
    idle(20);
    rchk("R4 frozen", A_RLD, 16'h0004);
    wr(A_RLD, 16'hBEEF);
    rchk("R3 reload", A_RLD, 16'h0009);
    idle(30);
    rchk("R4 frozen2", A_RLD, 16'h0009);
    rchk("R4 no status", A_SA, 16'h0000);

    // R4 run
    wr(A_CTL, 16'h0000);
    rchk("R4 ctrl read", A_CTL, 16'h0000);

    // R5/R6 sweep over N
    for (int nn = 4; nn <= 12; nn++) begin
      wr(A_SA, 16'h0001);
      wr(A_SB, 16'h0003);
      wr(A_INI, 16'(nn));
      wr(A_RLD, 16'h0000);
      for (int k = 0; k <= nn; k++) begin
        rchk("R5 count", A_RLD, 16'(nn - k));
        if (k < nn) idle(P);
      end
      rchk("R6 before", A_SA, 16'h0000);
      idle(P);
      rchk("R6 wrap count", A_RLD, 16'(nn));
      rchk("R6 stsA", A_SA, 16'h0001);
      rchk("R6 stsB", A_SB, 16'h0000);
    end

    // R7 guard set: reset withheld
    n = 5;
    wr(A_INI, 16'(n));
    wr(A_SA, 16'h0001);
    wr(A_SB, 16'h0003);
    wr(A_RLD, 16'h0000);
    idle(2 * (n + 1) * P - 1);
    rchk("R7 blk pre", A_SB, 16'h0000);
    idle(1);
    chk("R7 blk rst", {15'd0, sys_rst_req}, 16'h0000);
    rchk("R7 blk sts", A_SB, 16'h0002);
    rchk("R7 blk count", A_RLD, 16'(n));

    // R8 guard register
    wr(A_GRD, 16'h0000);
    rchk("R8 cleared", A_GRD, 16'h0000);
    wr(A_GRD, 16'h0001);
    rchk("R8 set", A_GRD, 16'h0001);
    wr(A_GRD, 16'h0000);

    // R7 guard clear: one-cycle reset
    wr(A_SB, 16'h0003);
    rchk("R9 clear B", A_SB, 16'h0000);
    wr(A_RLD, 16'h0000);
    idle(2 * (n + 1) * P - 1);
    chk("R7 rst pre", {15'd0, sys_rst_req}, 16'h0000);
    idle(1);
    chk("R7 rst high", {15'd0, sys_rst_req}, 16'h0001);
    rchk("R7 rst sts", A_SB, 16'h0001);
    idle(1);
    chk("R7 rst low", {15'd0, sys_rst_req}, 16'h0000);

    // R9 status clear
    wr(A_SB, 16'h0003);
    rchk("R9 B clr", A_SB, 16'h0000);
    wr(A_SA, 16'h0001);
    rchk("R9 A clr", A_SA, 16'h0000);
    // R9 set beats clear on the same edge
    wr(A_RLD, 16'h0000);
    idle((n + 1) * P - 1);
    wr(A_SA, 16'h0001);
    rchk("R9 set wins", A_SA, 16'h0001);

    // R10 reload on the expiry edge wins
    wr(A_SA, 16'h0001);
    wr(A_RLD, 16'h0000);
    idle((n + 1) * P - 1);
    wr(A_RLD, 16'h0000);
    rchk("R10 same edge cnt", A_RLD, 16'(n));
    rchk("R10 same edge sts", A_SA, 16'h0000);

    // R10 reload clears tracking (guard is 0)
    wr(A_SA, 16'h0001);
    wr(A_SB, 16'h0003);
    wr(A_RLD, 16'h0000);
    idle((n + 1) * P);
    rchk("R10 first", A_SA, 16'h0001);
    wr(A_RLD, 16'h0000);
    wr(A_SA, 16'h0001);
    idle((n + 1) * P - 1);
    chk("R10 no rst", {15'd0, sys_rst_req}, 16'h0000);
    rchk("R10 stsB", A_SB, 16'h0000);
    rchk("R10 first again", A_SA, 16'h0001);

    // R4 halt mid-count
    wr(A_RLD, 16'h0000);
    idle(2 * P);
    wr(A_CTL, 16'h0800);
    rchk("R4 mid", A_RLD, 16'(n - 2));
    idle(25);
    rchk("R4 mid hold", A_RLD, 16'(n - 2));
    rchk("R4 halt read", A_CTL, 16'h0800);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule